// File: doc/BRIEF.md
# Static Memory Bus Bridge

This block connects one internal master to an external asynchronous memory bus. The master issues one 32-bit word read or write at a time. The bridge picks a chip select from the address, runs one or more external cycles, and then answers with a one-cycle response pulse. On the external side it drives active-low chip selects, an output enable, separate write strobes for the low and high byte lanes, an upper-byte select, and a 16-bit data bus. The data bus is split into an output half, an input half and an output-enable.

Each chip select has its own configuration word, written through a small write-only register port. The word sets:

- the region base and region size,
- whether the select is enabled,
- an 8-bit or 16-bit data path,
- early-read timing,
- a wait-state count from 0 to 7.

A word access becomes two external cycles to a 16-bit device, or four to an 8-bit device. The cycles run in ascending byte order. An active-low wait input stretches any external cycle for as long as it is held.

With separate low and high write strobes, two 8-bit parts can stand in for one 16-bit device. Early-read timing lowers output enable together with the chip select, which removes the setup cycle from every read cycle.

Top module: `smem_bridge`

## Requirements
- R1: After synchronous reset, every chip select, the output enable, both write strobes and the upper-byte select are high. The data output-enable and the response pulse are low, the request-ready output is high, and every chip select is disabled, so any access is treated as unmapped.
- R2: The configuration word has this layout: bits [31:20] base, bits [10:8] size code s, bit 5 enable, bit 4 early read, bit 3 width (1 = 16-bit), bits [2:0] wait states. A request address hits an enabled select when its bits [31:20+s] equal the matching base bits, which gives a region of 2^(20+s) bytes.
- R3: When several enabled regions contain the address, the select with the lowest index runs the access.
- R4: An address that hits no select gets a response in the first cycle after acceptance, with read data 0 and no chip select asserted.
- R5: A word access runs two external cycles on a 16-bit select and four on an 8-bit select. Each external cycle covers the next higher byte address. Read data is assembled so that the lowest byte address lands in bits [7:0], and write data is sent in the same order.
- R6: On a 16-bit select, the upper-byte select is low and external address bit 0 is 0 (the low-byte select, active). Writes drive both byte strobes and put data on all 16 lines. On an 8-bit select, only the low strobe is used, data uses bits [7:0], and the upper-byte select stays high.
- R7: Writes, and reads on a select without early read, spend one setup cycle per external cycle. In that cycle the chip select is low and the output enable and write strobes are high. A strobe phase of (wait states + 1) cycles follows.
- R8: Reads on an early-read select lower the output enable in the same cycle as the chip select. Each external cycle then lasts (wait states + 1) cycles.
- R9: While the wait input is low at the clock edge that would end a strobe phase, the phase continues. Read data is taken at the edge where the phase ends.
- R10: The response pulse lasts exactly one cycle. It comes one cycle after the edge that ends the last external cycle, so its cycle number after acceptance is beats × (setup + wait states + 1) + 1 plus any wait stretch. All chip selects are high during the pulse.
- R11: Request-ready is high only while the bridge is idle. The output enable and the low write strobe are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | SEL_W | Index of the chip select being configured |
| cfg_wdata | input | 32 | Configuration word |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Bridge idle; request accepted at this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address (bits [1:0] ignored) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Assembled read data |
| ext_ncs | output | NUM_CS | Active-low chip selects |
| ext_addr | output | EXT_AW | External byte address |
| ext_noe | output | 1 | Active-low output enable |
| ext_nwe_lo | output | 1 | Active-low write strobe, low byte lane |
| ext_nwe_hi | output | 1 | Active-low write strobe, high byte lane |
| ext_nub | output | 1 | Active-low upper-byte select |
| ext_dq_out | output | 16 | Data driven to the bus |
| ext_dq_oe | output | 1 | Data drive enable |
| ext_dq_in | input | 16 | Data read from the bus |
| ext_nwait | input | 1 | Active-low wait |

## Verification
All pins are registered from the next-state logic, so every result is tied to a cycle count after the acceptance edge. The response is due in cycle beats × (setup + wait states + 1) + 1, where setup is 0 for early reads and 1 otherwise. A held wait adds the cycles it covers past the first strobe phase's end, and an unmapped access answers in cycle 1. The bench samples at falling edges, numbers the cycles from acceptance, and compares the cycle in which the pulse appears with this formula. It also takes a snapshot of the chip selects, output enable and ready in cycle 1 to check the setup or early-read start. Write data is captured from the strobes at rising edges and compared only after the response.

// File: rtl/smem_pkg.sv
package smem_pkg;

  localparam int REGION_SHIFT = 20;
  localparam int BASE_W       = 32 - REGION_SHIFT;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [2:0]        size;
    logic              en;
    logic              early;
    logic              wide;
    logic [2:0]        ws;
  } cs_cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_DONE
  } seq_state_t;

  function automatic cs_cfg_t unpack_cfg(input logic [31:0] w);
    cs_cfg_t c;
    c.base  = w[31:REGION_SHIFT];
    c.size  = w[10:8];
    c.en    = w[5];
    c.early = w[4];
    c.wide  = w[3];
    c.ws    = w[2:0];
    return c;
  endfunction

endpackage

// File: rtl/smem_cfg_regs.sv
module smem_cfg_regs #(
  parameter int NUM_CS = 4,
  localparam int SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              cfg_we,
  input  logic [SEL_W-1:0]                  cfg_sel,
  input  logic [31:0]                       cfg_wdata,
  output smem_pkg::cs_cfg_t [NUM_CS-1:0]    cfg_q
);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q[g] <= '0;
      end else if (cfg_we && cfg_sel == SEL_W'(g)) begin
        cfg_q[g] <= smem_pkg::unpack_cfg(cfg_wdata);
      end
    end
  end

endmodule

// File: rtl/smem_cs_decode.sv
module smem_cs_decode #(
  parameter int NUM_CS = 4,
  localparam int SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  smem_pkg::cs_cfg_t [NUM_CS-1:0]    cfg_q,
  input  logic [smem_pkg::BASE_W-1:0]       addr_hi,
  output logic                              hit,
  output logic [SEL_W-1:0]                  hit_idx,
  output smem_pkg::cs_cfg_t                 hit_cfg
);

  localparam int BW = smem_pkg::BASE_W;

  logic [NUM_CS-1:0] match;

  // Per-select region compare; the size code masks low base bits out.
  for (genvar g = 0; g < NUM_CS; g++) begin : g_match
    logic [BW-1:0] care;
    assign care     = {BW{1'b1}} << cfg_q[g].size;
    assign match[g] = cfg_q[g].en && (((addr_hi ^ cfg_q[g].base) & care) == '0);
  end

  // Lowest index wins (R3): scan downward so the last assignment is the lowest.
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit     = 1'b1;
        hit_idx = SEL_W'(i);
      end
    end
  end

  assign hit_cfg = cfg_q[hit_idx];

endmodule

// File: rtl/smem_seq.sv
module smem_seq #(
  parameter int NUM_CS = 4,
  parameter int EXT_AW = 20,
  localparam int SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [EXT_AW-1:2]        req_word,
  input  logic [31:0]              req_wdata,
  input  logic                     hit,
  input  logic [SEL_W-1:0]         hit_idx,
  input  smem_pkg::cs_cfg_t        hit_cfg,
  input  logic [15:0]              ext_dq_in,
  input  logic                     ext_nwait,
  output logic                     req_ready,
  output logic                     rsp_valid,
  output logic [31:0]              rsp_rdata,
  output logic [NUM_CS-1:0]        ext_ncs,
  output logic [EXT_AW-1:0]        ext_addr,
  output logic                     ext_noe,
  output logic                     ext_nwe_lo,
  output logic                     ext_nwe_hi,
  output logic                     ext_nub,
  output logic [15:0]              ext_dq_out,
  output logic                     ext_dq_oe
);

  import smem_pkg::*;

  seq_state_t         st_q, st_d;
  logic [SEL_W-1:0]   sel_q, sel_d;
  logic               wide_q, wide_d;
  logic               early_q, early_d;
  logic               write_q, write_d;
  logic [2:0]         ws_q, ws_d;
  logic [2:0]         wcnt_q, wcnt_d;
  logic [1:0]         beat_q, beat_d;
  logic [EXT_AW-1:2]  word_q, word_d;
  logic [31:0]        wdata_q, wdata_d;
  logic [31:0]        rdata_q, rdata_d;

  logic last_beat;
  assign last_beat = wide_q ? (beat_q == 2'd1) : (beat_q == 2'd3);

  always_comb begin
    st_d    = st_q;
    sel_d   = sel_q;
    wide_d  = wide_q;
    early_d = early_q;
    write_d = write_q;
    ws_d    = ws_q;
    wcnt_d  = wcnt_q;
    beat_d  = beat_q;
    word_d  = word_q;
    wdata_d = wdata_q;
    rdata_d = rdata_q;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          write_d = req_write;
          word_d  = req_word;
          wdata_d = req_wdata;
          rdata_d = '0;
          beat_d  = '0;
          if (hit) begin
            sel_d   = hit_idx;
            wide_d  = hit_cfg.wide;
            early_d = hit_cfg.early;
            ws_d    = hit_cfg.ws;
            wcnt_d  = hit_cfg.ws;
            st_d    = (!req_write && hit_cfg.early) ? ST_STROBE : ST_SETUP;
          end else begin
            st_d = ST_DONE;
          end
        end
      end
      ST_SETUP: begin
        wcnt_d = ws_q;
        st_d   = ST_STROBE;
      end
      ST_STROBE: begin
        if (wcnt_q != 3'd0) begin
          wcnt_d = wcnt_q - 3'd1;
        end else if (ext_nwait) begin
          if (!write_q) begin
            if (wide_q) rdata_d[{beat_q[0], 4'b0000} +: 16] = ext_dq_in;
            else        rdata_d[{beat_q, 3'b000} +: 8]      = ext_dq_in[7:0];
          end
          if (last_beat) begin
            st_d = ST_DONE;
          end else begin
            beat_d = beat_q + 2'd1;
            wcnt_d = ws_q;
            st_d   = (!write_q && early_q) ? ST_STROBE : ST_SETUP;
          end
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      sel_q   <= '0;
      wide_q  <= 1'b0;
      early_q <= 1'b0;
      write_q <= 1'b0;
      ws_q    <= '0;
      wcnt_q  <= '0;
      beat_q  <= '0;
      word_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      st_q    <= st_d;
      sel_q   <= sel_d;
      wide_q  <= wide_d;
      early_q <= early_d;
      write_q <= write_d;
      ws_q    <= ws_d;
      wcnt_q  <= wcnt_d;
      beat_q  <= beat_d;
      word_q  <= word_d;
      wdata_q <= wdata_d;
      rdata_q <= rdata_d;
    end
  end

  // Pin stage: every pin is a flop loaded from the next-state decode,
  // so the asynchronous bus never sees a combinational glitch.
  logic        act_d;
  logic        strobe_d;
  logic [1:0]  low_d;
  logic [15:0] dq_d;

  assign act_d    = (st_d == ST_SETUP) || (st_d == ST_STROBE);
  assign strobe_d = (st_d == ST_STROBE);
  assign low_d    = wide_d ? {beat_d[0], 1'b0} : beat_d;
  assign dq_d     = wide_d ? wdata_d[{beat_d[0], 4'b0000} +: 16]
                           : {8'h00, wdata_d[{beat_d, 3'b000} +: 8]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_ncs    <= '1;
      ext_addr   <= '0;
      ext_noe    <= 1'b1;
      ext_nwe_lo <= 1'b1;
      ext_nwe_hi <= 1'b1;
      ext_nub    <= 1'b1;
      ext_dq_out <= '0;
      ext_dq_oe  <= 1'b0;
      req_ready  <= 1'b1;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      for (int i = 0; i < NUM_CS; i++) begin
        ext_ncs[i] <= !(act_d && sel_d == SEL_W'(i));
      end
      ext_addr   <= act_d ? {word_d, low_d} : '0;
      ext_noe    <= !(act_d && !write_d && (strobe_d || early_d));
      ext_nwe_lo <= !(strobe_d && write_d);
      ext_nwe_hi <= !(strobe_d && write_d && wide_d);
      ext_nub    <= !(act_d && wide_d);
      ext_dq_out <= (act_d && write_d) ? dq_d : '0;
      ext_dq_oe  <= act_d && write_d;
      req_ready  <= (st_d == ST_IDLE);
      rsp_valid  <= (st_d == ST_DONE);
      rsp_rdata  <= rdata_d;
    end
  end

endmodule

// File: rtl/smem_bridge.sv
module smem_bridge #(
  parameter int NUM_CS = 4,
  parameter int EXT_AW = 20,
  localparam int SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [SEL_W-1:0]   cfg_sel,
  input  logic [31:0]        cfg_wdata,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [31:0]        req_addr,
  input  logic [31:0]        req_wdata,
  output logic               rsp_valid,
  output logic [31:0]        rsp_rdata,
  output logic [NUM_CS-1:0]  ext_ncs,
  output logic [EXT_AW-1:0]  ext_addr,
  output logic               ext_noe,
  output logic               ext_nwe_lo,
  output logic               ext_nwe_hi,
  output logic               ext_nub,
  output logic [15:0]        ext_dq_out,
  output logic               ext_dq_oe,
  input  logic [15:0]        ext_dq_in,
  input  logic               ext_nwait
);

  smem_pkg::cs_cfg_t [NUM_CS-1:0] cfg_q;
  smem_pkg::cs_cfg_t              hit_cfg;
  logic                           hit;
  logic [SEL_W-1:0]               hit_idx;
  logic                           unused_lsb;

  assign unused_lsb = ^req_addr[1:0];

  smem_cfg_regs #(.NUM_CS(NUM_CS)) i_cfg (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .cfg_q     (cfg_q)
  );

  smem_cs_decode #(.NUM_CS(NUM_CS)) i_dec (
    .cfg_q   (cfg_q),
    .addr_hi (req_addr[31:smem_pkg::REGION_SHIFT]),
    .hit     (hit),
    .hit_idx (hit_idx),
    .hit_cfg (hit_cfg)
  );

  smem_seq #(.NUM_CS(NUM_CS), .EXT_AW(EXT_AW)) i_seq (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_word   (req_addr[EXT_AW-1:2]),
    .req_wdata  (req_wdata),
    .hit        (hit),
    .hit_idx    (hit_idx),
    .hit_cfg    (hit_cfg),
    .ext_dq_in  (ext_dq_in),
    .ext_nwait  (ext_nwait),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .ext_ncs    (ext_ncs),
    .ext_addr   (ext_addr),
    .ext_noe    (ext_noe),
    .ext_nwe_lo (ext_nwe_lo),
    .ext_nwe_hi (ext_nwe_hi),
    .ext_nub    (ext_nub),
    .ext_dq_out (ext_dq_out),
    .ext_dq_oe  (ext_dq_oe)
  );

endmodule

// File: rtl/smem_bridge_chk.sv
module smem_bridge_chk #(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [NUM_CS-1:0] ext_ncs,
  input logic              ext_noe,
  input logic              ext_nwe_lo,
  input logic              ext_nwe_hi,
  input logic              ext_nub,
  input logic              ext_dq_oe,
  input logic              ext_nwait
);

  a_r3_single_cs: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~ext_ncs));

  a_r7_strobe_needs_cs: assert property (@(posedge clk) disable iff (rst)
    (!ext_nwe_lo || !ext_noe) |-> !(&ext_ncs));

  a_r6_hi_lane_uses_nub: assert property (@(posedge clk) disable iff (rst)
    !ext_nwe_hi |-> !ext_nub);

  a_r7_no_drive_on_read: assert property (@(posedge clk) disable iff (rst)
    ext_dq_oe |-> ext_noe);

  a_r9_wait_holds_cycle: assert property (@(posedge clk) disable iff (rst)
    (!ext_nwait && (!ext_noe || !ext_nwe_lo)) |=> !(&ext_ncs));

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  a_r10_bus_released: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> &ext_ncs);

  a_r11_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready);

  a_r11_oe_we_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(!ext_noe && !ext_nwe_lo));

endmodule

bind smem_bridge smem_bridge_chk #(.NUM_CS(NUM_CS)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .ext_ncs    (ext_ncs),
  .ext_noe    (ext_noe),
  .ext_nwe_lo (ext_nwe_lo),
  .ext_nwe_hi (ext_nwe_hi),
  .ext_nub    (ext_nub),
  .ext_dq_oe  (ext_dq_oe),
  .ext_nwait  (ext_nwait)
);

// File: tb/test_smem_bridge.sv
module test_smem_bridge;

  localparam int NUM_CS = 4;
  localparam int EXT_AW = 20;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst;
  logic              cfg_we;
  logic [1:0]        cfg_sel;
  logic [31:0]       cfg_wdata;
  logic              req_valid, req_ready, req_write;
  logic [31:0]       req_addr, req_wdata;
  logic              rsp_valid;
  logic [31:0]       rsp_rdata;
  logic [NUM_CS-1:0] ext_ncs;
  logic [EXT_AW-1:0] ext_addr;
  logic              ext_noe, ext_nwe_lo, ext_nwe_hi, ext_nub, ext_dq_oe;
  logic [15:0]       ext_dq_out, ext_dq_in;
  logic              ext_nwait;

  smem_bridge #(.NUM_CS(NUM_CS), .EXT_AW(EXT_AW)) i_smem_bridge (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .ext_ncs(ext_ncs), .ext_addr(ext_addr), .ext_noe(ext_noe),
    .ext_nwe_lo(ext_nwe_lo), .ext_nwe_hi(ext_nwe_hi), .ext_nub(ext_nub),
    .ext_dq_out(ext_dq_out), .ext_dq_oe(ext_dq_oe), .ext_dq_in(ext_dq_in),
    .ext_nwait(ext_nwait)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // Device model: each byte is a function of its address and the select.
  function automatic logic [7:0] pat(input logic [7:0] a, input int c);
    return a ^ (8'h15 + 8'(c * 64));
  endfunction

  function automatic logic [31:0] exp_word(input logic [7:0] o, input int c);
    return {pat(o + 8'd3, c), pat(o + 8'd2, c), pat(o + 8'd1, c), pat(o, c)};
  endfunction

  function automatic int exp_lat(input bit wide, input bit early_rd, input int ws, input int x);
    int beats = wide ? 2 : 4;
    int s     = early_rd ? 0 : 1;
    int extra = (x > s + ws) ? x - (s + ws) : 0;
    return beats * (s + ws + 1) + 1 + extra;
  endfunction

  function automatic logic [31:0] cfgw(input logic [11:0] base, input logic [2:0] size,
                                       input bit en, input bit early, input bit wide,
                                       input logic [2:0] ws);
    return {base, 9'b0, size, 2'b0, en, early, wide, ws};
  endfunction

  always_comb begin
    int c;
    c = 0;
    for (int i = 0; i < NUM_CS; i++) if (!ext_ncs[i]) c = i;
    ext_dq_in = {pat(ext_addr[7:0] | 8'd1, c), pat(ext_addr[7:0], c)};
  end

  // Bus monitor
  logic [7:0]        wmem [256];
  int                fall_lo;
  bit                hi_seen, nub_seen;
  logic [NUM_CS-1:0] cs_seen;
  logic              prev_lo = 1'b1;

  always @(posedge clk) begin
    if (!ext_nwe_lo) wmem[ext_addr[7:0]] <= ext_dq_out[7:0];
    if (!ext_nwe_hi) wmem[{ext_addr[7:1], 1'b1}] <= ext_dq_out[15:8];
    if (prev_lo && !ext_nwe_lo) fall_lo++;
    prev_lo = ext_nwe_lo;
    if (!ext_nwe_hi) hi_seen = 1'b1;
    if (!ext_nub) nub_seen = 1'b1;
    cs_seen = cs_seen | ~ext_ncs;
  end

  task automatic cfg_write(input int sel, input logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access(input bit wr, input logic [31:0] addr, input logic [31:0] wd,
                        input int x, output int lat, output logic [31:0] rd,
                        output logic [NUM_CS-1:0] ncs1, output logic noe1, output logic rdy1);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    fall_lo = 0; hi_seen = 1'b0; nub_seen = 1'b0; cs_seen = '0;
    for (int i = 0; i < 256; i++) wmem[i] = 8'h00;
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
    @(posedge clk);
    lat = 0; rd = '0; ncs1 = '1; noe1 = 1'b1; rdy1 = 1'b1;
    while (lat < 300) begin
      @(negedge clk);
      lat++;
      req_valid = 1'b0;
      ext_nwait = (lat > x);
      if (lat == 1) begin ncs1 = ext_ncs; noe1 = ext_noe; rdy1 = req_ready; end
      if (rsp_valid) begin rd = rsp_rdata; break; end
    end
    ext_nwait = 1'b1;
  endtask

  task automatic run_read(input string rq, input logic [31:0] addr, input int cs,
                          input bit wide, input bit early, input int ws, input int x);
    int lat, el;
    logic [31:0] rd;
    logic [NUM_CS-1:0] n1;
    logic o1, r1;
    access(1'b0, addr, 32'h0, x, lat, rd, n1, o1, r1);
    if (cs < 0) begin
      chk(lat == 1, rq, "unmapped latency", lat, 1);
      chk(rd == 32'h0, rq, "unmapped data", rd, 0);
      chk(cs_seen == '0, rq, "unmapped chip select", 32'(cs_seen), 0);
    end else begin
      el = exp_lat(wide, early, ws, x);
      chk(lat == el, rq, "read latency (R10)", lat, el);
      chk(rd == exp_word(addr[7:0], cs), rq, "read data (R5)", rd, exp_word(addr[7:0], cs));
      chk(cs_seen == NUM_CS'(1 << cs), rq, "select used", 32'(cs_seen), 32'(1 << cs));
      chk(n1 == ~NUM_CS'(1 << cs), rq, "select low in cycle 1", 32'(n1), 32'(~NUM_CS'(1 << cs)));
      chk(o1 == !early, rq, "output enable in cycle 1 (R7/R8)", 32'(o1), 32'(!early));
      chk(r1 == 1'b0, rq, "ready low while busy (R11)", 32'(r1), 0);
      chk(fall_lo == 0, rq, "no write strobe on read", fall_lo, 0);
      chk(nub_seen == wide, rq, "upper-byte select (R6)", 32'(nub_seen), 32'(wide));
    end
  endtask

  task automatic run_write(input string rq, input logic [31:0] addr, input logic [31:0] wd,
                           input int cs, input bit wide, input int ws, input int x);
    int lat, el;
    logic [31:0] rd, got;
    logic [NUM_CS-1:0] n1;
    logic o1, r1;
    access(1'b1, addr, wd, x, lat, rd, n1, o1, r1);
    @(negedge clk);
    el  = exp_lat(wide, 1'b0, ws, x);
    got = {wmem[addr[7:0] + 8'd3], wmem[addr[7:0] + 8'd2], wmem[addr[7:0] + 8'd1], wmem[addr[7:0]]};
    chk(lat == el, rq, "write latency (R10)", lat, el);
    chk(got == wd, rq, "written bytes (R5)", got, wd);
    chk(fall_lo == (wide ? 2 : 4), rq, "external cycles (R5)", fall_lo, wide ? 2 : 4);
    chk(hi_seen == wide, rq, "high byte strobe (R6)", 32'(hi_seen), 32'(wide));
    chk(o1 == 1'b1, rq, "setup cycle output enable high (R7)", 32'(o1), 1);
    chk(cs_seen == NUM_CS'(1 << cs), rq, "select used", 32'(cs_seen), 32'(1 << cs));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    ext_nwait = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: pin state after reset
    chk(ext_ncs == '1, "R1", "chip selects", 32'(ext_ncs), 32'hF);
    chk({ext_noe, ext_nwe_lo, ext_nwe_hi, ext_nub} == 4'hF, "R1", "strobes",
        32'({ext_noe, ext_nwe_lo, ext_nwe_hi, ext_nub}), 32'hF);
    chk(ext_dq_oe == 1'b0, "R1", "data drive", 32'(ext_dq_oe), 0);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R1", "ready/response",
        32'({req_ready, rsp_valid}), 32'h2);
    // R1: all selects disabled, so this is unmapped
    run_read("R1", 32'h0000_0040, -1, 1'b0, 1'b0, 0, 0);

    // Region map
    cfg_write(0, cfgw(12'h000, 3'd1, 1'b1, 1'b0, 1'b1, 3'd1)); // 2 MB, 16-bit
    cfg_write(1, cfgw(12'h004, 3'd0, 1'b1, 1'b0, 1'b0, 3'd0)); // 1 MB, 8-bit
    cfg_write(3, cfgw(12'h004, 3'd0, 1'b0, 1'b0, 1'b1, 3'd0)); // disabled overlap

    run_read("R2", 32'h0010_0020, 0, 1'b1, 1'b0, 1, 0);         // second MB of select 0
    run_read("R4", 32'h0020_0020, -1, 1'b0, 1'b0, 0, 0);        // just past select 0
    run_read("R5", 32'h0040_0010, 1, 1'b0, 1'b0, 0, 0);         // 8-bit, four cycles
    run_write("R6", 32'h0040_0030, 32'hCAFE_F00D, 1, 1'b0, 0, 0);
    run_write("R6", 32'h0000_0050, 32'h8421_1248, 0, 1'b1, 1, 0);

    // R3: enabled overlap, lower index wins
    cfg_write(3, cfgw(12'h004, 3'd0, 1'b1, 1'b0, 1'b1, 3'd0));
    run_read("R3", 32'h0040_0044, 1, 1'b0, 1'b0, 0, 0);
    // R2: size code 2 ignores two base bits; 0x0060_0000 falls only in select 3
    cfg_write(1, cfgw(12'h004, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0));
    cfg_write(3, cfgw(12'h005, 3'd2, 1'b1, 1'b0, 1'b1, 3'd0));
    run_read("R2", 32'h0060_0088, 3, 1'b1, 1'b0, 0, 0);

    // R9: wait stretches the first strobe phase
    cfg_write(2, cfgw(12'h008, 3'd0, 1'b1, 1'b0, 1'b1, 3'd0));
    run_write("R9", 32'h0080_0060, 32'h0BAD_BEEF, 2, 1'b1, 0, 3);
    cfg_write(2, cfgw(12'h008, 3'd0, 1'b1, 1'b1, 1'b1, 3'd1));
    run_read("R9", 32'h0080_0064, 2, 1'b1, 1'b1, 1, 4);

    // R7 R8 R10: sweep width, read mode and wait states on select 2
    for (int wide = 0; wide < 2; wide++) begin
      for (int early = 0; early < 2; early++) begin
        for (int ws = 0; ws < 8; ws++) begin
          logic [31:0] a;
          a = 32'h0080_0000 | 32'(ws * 16 + wide * 8 + early * 4);
          cfg_write(2, cfgw(12'h008, 3'd0, 1'b1, early[0], wide[0], 3'(ws)));
          run_read(early != 0 ? "R8" : "R7", a, 2, wide[0], early[0], ws, 0);
          run_write("R10", a, 32'h1357_9BDF ^ 32'(ws * 4099 + wide * 77 + early * 5),
                    2, wide[0], ws, 0);
        end
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule